// File: doc/BRIEF.md
# Segmented Byte-Fetch Instruction Sequencer

This block is a minimal processor control unit. It runs a fetch, decode and execute loop over a byte-wide instruction stream. Every memory reference is built from a 16-bit segment and a 16-bit offset: the segment is multiplied by sixteen, the offset is added, and the sum is kept to 20 bits. Opcode bytes are read one per machine cycle through the code segment and the instruction pointer. The pointer advances by one after each byte.

The decoder knows two instructions. The first is the two-byte pair 0x88 0x07. After the first byte the unit knows only that the instruction moves a byte to memory, so it spends a second machine cycle fetching the operand byte. It then writes the low accumulator byte (AL) to the data segment plus the base register (DS:BX). The second instruction is the one-byte halt, 0xF4. Any other opcode, or any other operand byte after 0x88, also stops the unit and raises a fault flag.

Reset is synchronous. It loads the segment, pointer, base and accumulator registers from input ports.

The memory port is a plain synchronous bus with no handshake, because wait states are not supported. It has a 16-bit data path split into an even (low) byte lane and an odd (high) byte lane. Every machine cycle lasts a fixed number of clocks. The strobe is driven in the first clock, and read data returns one clock after the strobe.

Top module: `seg_fetch_seq`

## Requirements
- R1: Every bus address equals segment×16 + offset, truncated to 20 bits (for example 1000:0005 gives 0x10005, and FFFF:0031 gives 0x00021).
- R2: Opcode and operand fetches use CS:IP. IP increases by one after every fetched byte and wraps from 0xFFFF to 0x0000.
- R3: Each machine cycle lasts CYC_STATES clocks (default 4). The strobe (`bus_rd` or `bus_wr`) is high only in the first clock of a cycle, so consecutive accesses start exactly CYC_STATES clocks apart.
- R4: Opcode 0x88 followed by operand byte 0x07 produces exactly one write of AL to DS:BX in the next machine cycle. Fetching then resumes at the byte after 0x07.
- R5: Opcode 0xF4 raises `halted` with `fault` low. After that the unit issues no further bus access, and both flags hold until reset.
- R6: Byte-lane selection: an access to an even address sets `bus_be` = 2'b01 and uses `bus_rdata[7:0]`. An access to an odd address sets `bus_be` = 2'b10 and uses `bus_rdata[15:8]`. `bus_be` is 2'b00 whenever no strobe is high.
- R7: During a write, `bus_wdata` carries AL on both lanes, and only the strobe of the addressed lane is set. The other byte of the memory word is left unchanged.
- R8: An opcode other than 0x88 or 0xF4, or an operand byte other than 0x07 after 0x88, sets both `halted` and `fault`. No write follows.
- R9: While `rst_n` is low at a clock edge, the unit loads CS, IP, DS, BX and AL from the init ports, clears `halted` and `fault`, and presents CS:IP on `bus_addr`. The first access after reset is an opcode read at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the init values |
| init_cs | input | 16 | Code segment loaded at reset |
| init_ip | input | 16 | Instruction pointer loaded at reset |
| init_ds | input | 16 | Data segment loaded at reset |
| init_bx | input | 16 | Base register loaded at reset |
| init_al | input | 8 | Accumulator low byte loaded at reset |
| bus_addr | output | 20 | Physical byte address of the current machine cycle |
| bus_rd | output | 1 | Read strobe, high during the first clock of a fetch cycle |
| bus_wr | output | 1 | Write strobe, high during the first clock of a store cycle |
| bus_be | output | 2 | Byte-lane enables: bit 0 is the even lane, bit 1 is the odd lane |
| bus_wdata | output | 16 | Write data, with AL on both lanes |
| bus_rdata | input | 16 | Read data, valid one clock after `bus_rd` |
| halted | output | 1 | Unit has stopped |
| fault | output | 1 | Stop was caused by an unrecognised byte |

## Verification
The pointer increment and the decode decision take effect on the same closing clock of a fetch cycle. The next cycle must therefore address the incremented pointer while also switching to the store's DS:BX source or to the stopped state. The bench provokes this with IP starting at 0xFFFE and with segment sums that overflow 20 bits, and it sweeps odd and even pointer and base values. It judges the outcome only from the address, lane enables, strobe kind, data and spacing of every recorded bus access, compared against sequences computed from segment×16+offset arithmetic.

// File: rtl/seqpkg.sv
package seqpkg;
  typedef enum logic [1:0] {
    MC_OPCODE  = 2'd0,
    MC_OPERAND = 2'd1,
    MC_STORE   = 2'd2,
    MC_STOP    = 2'd3
  } mcyc_e;

  localparam logic [7:0] OPC_BYTE_STORE = 8'h88;
  localparam logic [7:0] OPC_STOP       = 8'hF4;
  localparam logic [7:0] OPND_AL_AT_BX  = 8'h07;
endpackage

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
  parameter int SEG_W = 16,
  localparam int PA_W = SEG_W + 4
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [SEG_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  // segment scaled by sixteen plus offset; carry out of the top bit is dropped
  assign pa = {seg, 4'b0000} + {4'b0000, off};
endmodule

// File: rtl/seq_lane_steer.sv
module seq_lane_steer #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int SELW  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [SELW-1:0]   sel,
  input  logic              strobe,
  input  logic [LANE_W-1:0] wbyte,
  input  logic [DW-1:0]     rdata,
  output logic [LANES-1:0]  be,
  output logic [DW-1:0]     wdata,
  output logic [LANE_W-1:0] rbyte
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = strobe && (sel == SELW'(g));
    assign wdata[g*LANE_W +: LANE_W] = wbyte;
  end

  always_comb begin
    rbyte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sel == SELW'(i)) rbyte = rdata[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seqpkg::*;
(
  input  mcyc_e       kind,
  input  logic [7:0]  code,
  output mcyc_e       next_kind,
  output logic        bad
);
  always_comb begin
    next_kind = MC_STOP;
    bad       = 1'b0;
    unique case (kind)
      MC_OPCODE: begin
        if (code == OPC_BYTE_STORE)  next_kind = MC_OPERAND;
        else if (code == OPC_STOP)   next_kind = MC_STOP;
        else                         bad = 1'b1;
      end
      MC_OPERAND: begin
        if (code == OPND_AL_AT_BX)   next_kind = MC_STORE;
        else                         bad = 1'b1;
      end
      MC_STORE: next_kind = MC_OPCODE;
      MC_STOP:  next_kind = MC_STOP;
      default:  next_kind = MC_STOP;
    endcase
  end
endmodule

// File: rtl/seg_fetch_seq.sv
module seg_fetch_seq
  import seqpkg::*;
#(
  parameter int SEG_W      = 16,
  parameter int CYC_STATES = 4,
  parameter int LANES      = 2,
  localparam int LANE_W    = 8,
  localparam int PA_W      = SEG_W + 4,
  localparam int DW        = LANES * LANE_W,
  localparam int SELW      = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TCW       = (CYC_STATES > 1) ? $clog2(CYC_STATES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  init_cs,
  input  logic [SEG_W-1:0]  init_ip,
  input  logic [SEG_W-1:0]  init_ds,
  input  logic [SEG_W-1:0]  init_bx,
  input  logic [LANE_W-1:0] init_al,
  output logic [PA_W-1:0]   bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [LANES-1:0]  bus_be,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              halted,
  output logic              fault
);
  logic [SEG_W-1:0]  cs_q, ip_q, ds_q, bx_q;
  logic [LANE_W-1:0] al_q, byte_q, rbyte, dec_in;
  logic [TCW-1:0]    tcnt;
  mcyc_e             kind_q, kind_nxt;
  logic              fault_q, dec_bad;
  logic              first_t, data_t, last_t, is_store, strobe;
  logic [SEG_W-1:0]  seg_sel, off_sel;

  assign first_t  = (tcnt == '0);
  assign data_t   = (tcnt == TCW'(1));
  assign last_t   = (tcnt == TCW'(CYC_STATES - 1));
  assign is_store = (kind_q == MC_STORE);

  assign seg_sel = is_store ? ds_q : cs_q;
  assign off_sel = is_store ? bx_q : ip_q;

  seq_addr_gen #(.SEG_W(SEG_W)) u_addr (
    .seg (seg_sel),
    .off (off_sel),
    .pa  (bus_addr)
  );

  assign bus_rd = first_t && (kind_q == MC_OPCODE || kind_q == MC_OPERAND);
  assign bus_wr = first_t && is_store;
  assign strobe = bus_rd || bus_wr;

  seq_lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .sel    (bus_addr[SELW-1:0]),
    .strobe (strobe),
    .wbyte  (al_q),
    .rdata  (bus_rdata),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .rbyte  (rbyte)
  );

  // the byte arrives in the second clock; take it live there so short cycles still decode it
  assign dec_in = data_t ? rbyte : byte_q;

  seq_decode u_dec (
    .kind      (kind_q),
    .code      (dec_in),
    .next_kind (kind_nxt),
    .bad       (dec_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= init_cs;
      ip_q    <= init_ip;
      ds_q    <= init_ds;
      bx_q    <= init_bx;
      al_q    <= init_al;
      byte_q  <= '0;
      tcnt    <= '0;
      kind_q  <= MC_OPCODE;
      fault_q <= 1'b0;
    end else if (kind_q != MC_STOP) begin
      tcnt <= last_t ? '0 : tcnt + TCW'(1);
      if (data_t) byte_q <= rbyte;
      if (last_t) begin
        if (!is_store) ip_q <= ip_q + SEG_W'(1);
        kind_q  <= kind_nxt;
        fault_q <= dec_bad;
      end
    end
  end

  assign halted = (kind_q == MC_STOP);
  assign fault  = fault_q;

  // ---------------- assertions ----------------
  a_r3_strobe_once_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));
  a_r3_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> $countones(bus_be) == 1);
  a_r6_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> bus_be == '0);
  a_r6_even_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_addr[0]) |-> bus_be[0]);
  a_r7_lane_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_wdata[LANE_W-1:0] == bus_wdata[DW-1 -: LANE_W]);
  a_r2_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd) |=> (ip_q == $past(ip_q)) || (CYC_STATES == 1));
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(fault));
  a_r5_silent_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !bus_rd && !bus_wr);
  a_r8_fault_implies_halt: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);
  a_r4_store_follows_operand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_store) |-> $past(kind_q) == MC_OPERAND);
endmodule

// File: tb/tb_seg_fetch_seq.sv
`timescale 1ns/1ps
module tb_seg_fetch_seq;
  localparam int CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] init_cs = '0, init_ip = '0, init_ds = '0, init_bx = '0;
  logic [7:0]  init_al = '0;
  logic [19:0] bus_addr;
  logic        bus_rd, bus_wr, halted, fault;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  always #4 clk = ~clk;

  seg_fetch_seq #(.CYC_STATES(CYC)) dut (
    .clk, .rst_n, .init_cs, .init_ip, .init_ds, .init_bx, .init_al,
    .bus_addr, .bus_rd, .bus_wr, .bus_be, .bus_wdata, .bus_rdata,
    .halted, .fault
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  logic [7:0] mem [logic [19:0]];

  function automatic logic [7:0] rdb(logic [19:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [19:0] pa(logic [15:0] s, logic [15:0] o);
    return {s, 4'b0} + {4'b0, o};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd) bus_rdata <= {rdb(bus_addr | 20'h1), rdb(bus_addr & ~20'h1)};
    if (rst_n && bus_wr) begin
      if (bus_be[0]) mem[bus_addr & ~20'h1] = bus_wdata[7:0];
      if (bus_be[1]) mem[bus_addr | 20'h1]  = bus_wdata[15:8];
    end
  end

  // recorded bus accesses
  int          n_ev = 0;
  logic [19:0] ev_a [64];
  logic        ev_w [64];
  logic [1:0]  ev_be[64];
  logic [15:0] ev_d [64];
  longint      ev_t [64];

  always @(negedge clk) begin
    if (rst_n && (bus_rd || bus_wr) && n_ev < 64) begin
      ev_a[n_ev]  = bus_addr;
      ev_w[n_ev]  = bus_wr;
      ev_be[n_ev] = bus_be;
      ev_d[n_ev]  = bus_wdata;
      ev_t[n_ev]  = cyc;
      n_ev++;
    end
  end

  // expected accesses
  int          n_exp;
  logic [19:0] ex_a [64];
  logic        ex_w [64];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [19:0] a, logic w);
    ex_a[n_exp] = a;
    ex_w[n_exp] = w;
    n_exp++;
  endtask

  // term: 0 = halt opcode, 1 = unknown opcode, 2 = 0x88 with bad operand byte
  task automatic run(logic [15:0] cs, logic [15:0] ip0, logic [15:0] ds,
                     logic [15:0] bx, logic [7:0] al, int nstore, int term);
    logic [15:0] ip;
    logic [19:0] da;
    logic [7:0]  nb_before;
    @(negedge clk);
    rst_n = 1'b0;
    init_cs = cs; init_ip = ip0; init_ds = ds; init_bx = bx; init_al = al;
    mem.delete();
    n_exp = 0;
    ip = ip0;
    da = pa(ds, bx);
    for (int s = 0; s < nstore; s++) begin
      mem[pa(cs, ip)] = 8'h88; push(pa(cs, ip), 1'b0); ip++;
      mem[pa(cs, ip)] = 8'h07; push(pa(cs, ip), 1'b0); ip++;
      push(da, 1'b1);
    end
    case (term)
      0: begin mem[pa(cs, ip)] = 8'hF4; push(pa(cs, ip), 1'b0); end
      1: begin mem[pa(cs, ip)] = 8'h12; push(pa(cs, ip), 1'b0); end
      default: begin
        mem[pa(cs, ip)] = 8'h88; push(pa(cs, ip), 1'b0); ip++;
        mem[pa(cs, ip)] = 8'h3F; push(pa(cs, ip), 1'b0);
      end
    endcase
    nb_before = rdb(da ^ 20'h1);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(halted == 1'b0, "R9", "halted in reset", halted, 0);
    chk(fault == 1'b0, "R9", "fault in reset", fault, 0);
    chk(bus_addr == pa(cs, ip0), "R9", "reset address", bus_addr, pa(cs, ip0));
    n_ev = 0;
    rst_n = 1'b1;
    for (int k = 0; k < 40 * CYC && !halted; k++) @(negedge clk);
    repeat (3 * CYC) @(negedge clk);
    chk(halted == 1'b1, "R5", "halted at end", halted, 1);
    chk(fault == (term != 0), "R8", "fault flag", fault, (term != 0));
    chk(n_ev == n_exp, "R5", "access count", n_ev, n_exp);
    for (int i = 0; i < n_ev && i < n_exp; i++) begin
      chk(ev_a[i] == ex_a[i], "R1", "address", ev_a[i], ex_a[i]);
      chk(ev_w[i] == ex_w[i], "R4", "access kind", ev_w[i], ex_w[i]);
      chk(ev_be[i] == (ex_a[i][0] ? 2'b10 : 2'b01), "R6", "lane enables",
          ev_be[i], (ex_a[i][0] ? 2'b10 : 2'b01));
      if (ex_w[i]) chk(ev_d[i] == {al, al}, "R7", "write data", ev_d[i], {al, al});
      if (i > 0) chk(ev_t[i] - ev_t[i-1] == CYC, "R3", "cycle spacing",
                     ev_t[i] - ev_t[i-1], CYC);
    end
    if (nstore > 0) begin
      chk(rdb(da) == al, "R4", "stored byte", rdb(da), al);
      chk(rdb(da ^ 20'h1) == nb_before, "R7", "neighbour byte", rdb(da ^ 20'h1), nb_before);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(16'h1000, 16'h0005, 16'h2000, 16'h0023, 8'h1C, 1, 0); // odd high-lane store
    run(16'h1000, 16'h0004, 16'h2000, 16'h0022, 8'hA5, 2, 0); // even lane, two stores
    run(16'hF000, 16'hFFFE, 16'h0100, 16'h0001, 8'h66, 1, 0); // R2 IP wrap
    run(16'hFFFF, 16'h0010, 16'hFFFF, 16'h0031, 8'hC3, 1, 0); // R1 20-bit wrap
    run(16'h1234, 16'h0000, 16'h0040, 16'h0007, 8'h99, 0, 1); // R8 unknown opcode
    run(16'h0200, 16'h0003, 16'h0300, 16'h0000, 8'h55, 1, 2); // R8 bad operand
    run(16'h0000, 16'h0000, 16'h8000, 16'hFFFF, 8'hFF, 3, 0);
    for (int k = 0; k < 16; k++)
      run(16'h0500, 16'(k), 16'h3000, 16'(k), 8'(k * 17), 1, k % 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule